// File: doc/BRIEF.md
# Prescaled PWM Output Generator

This block drives one pulse-width-modulated output from three programmed counts: a prescale divider, a period divider and a high-duration count. The input clock is first divided down into ticks, with one tick every (prescale + 1) clocks. A period counter then runs over (period + 1) ticks per output cycle. The output is high for the first high-duration ticks of each cycle and low for the rest. The output period is therefore the product of two separately programmed dividers. A long period can use a large prescale, and a short period can keep the prescale at zero so that the full range of the period divider is left for duty resolution.

Writes from the configuration port land in a shadow copy. The shadow copy moves into the active settings only when the period counter wraps, or while the generator is idle. An output cycle therefore always runs to completion with the settings it started with. A high-duration count equal to period + 1 gives a true 100% duty, and a count of zero gives 0%. Dropping the enable forces the output low and clears both counters. Raising it again starts a fresh cycle from the latest written settings.

Top module: `pwm_prescaled_gen`

## Requirements
- R1: While reset is applied, and while enable is low after reset, pwm_out is 0.
- R2: With enable held high, one output cycle (rising edge to rising edge of pwm_out) lasts (P+1)*(D+1) clock cycles, where P is the prescale count and D is the period count.
- R3: Each output cycle begins with pwm_out high for exactly H*(P+1) clock cycles, then low for the rest of the cycle, when 0 < H < D+1.
- R4: A high-duration count H = 0 keeps pwm_out constantly 0 while enabled.
- R5: H = D+1 keeps pwm_out constantly 1 while enabled (100% duty).
- R6: Any H greater than D+1 behaves as H = D+1, so pwm_out stays constantly 1.
- R7: A period count written as 0xFFFF is stored as 0xFFFE, so that D+1 still fits the 16-bit high-duration count. With D = 0xFFFF and H = 0xFFFF, pwm_out is therefore constantly 1.
- R8: A configuration write made while an output cycle is running does not change that cycle. The new P, D and H take effect from the next cycle boundary.
- R9: When enable is sampled low, pwm_out is 0 from the next clock and both counters return to zero. On the first clock edge that samples enable high again, a new cycle starts with the most recently written settings, and pwm_out is high from that edge when H > 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Generator enable; low holds the output low and the counters at zero |
| cfg_we | input | 1 | Write strobe for the three configuration counts |
| cfg_prescale | input | 16 | Prescale count P; a tick occurs every P+1 clocks |
| cfg_period | input | 16 | Period count D; a cycle lasts D+1 ticks (capped at 0xFFFE) |
| cfg_high | input | 16 | High-duration count H, in ticks (capped at D+1) |
| pwm_out | output | 1 | Registered PWM output |

## Verification
On every cycle, the assertions check four things. The active period count never exceeds its cap, and the active high count never exceeds period + 1. Neither counter passes its active limit. The active settings hold still on any cycle that is not a boundary. They also check the output levels implied by zero duty, full duty and an idle enable. What the assertions cannot show are the cycle counts seen at the pin: the exact period and high time for several prescale and period mixes, and the deferral of a write made mid-cycle to the following cycle. The bench's directed scenarios show these, along with the fresh start of a cycle after enable returns.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Width of each programmed count
  parameter int unsigned PWM_W = 16;
  // Largest accepted period count: leaves room for period + 1 in PWM_W bits
  localparam logic [PWM_W-1:0] PER_MAX = PWM_W'((1 << PWM_W) - 2);

  typedef struct packed {
    logic [PWM_W-1:0] pre_div;
    logic [PWM_W-1:0] per_div;
    logic [PWM_W-1:0] hi_cnt;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_cfg_bank.sv
module pwm_cfg_bank
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  pwm_cfg_t wr_cfg,
  input  logic     load,
  output pwm_cfg_t act_q,
  output pwm_cfg_t act_d
);
  localparam int unsigned XW = PWM_W + 1;

  pwm_cfg_t         sh_q, sh_d;
  logic [XW-1:0]    hi_lim;
  logic [PWM_W-1:0] per_w;

  // Shadow next state: clamp period, then clamp high count against it
  always_comb begin
    sh_d   = sh_q;
    per_w  = (wr_cfg.per_div > PER_MAX) ? PER_MAX : wr_cfg.per_div;
    hi_lim = {1'b0, per_w} + XW'(1);
    if (wr_en) begin
      sh_d.pre_div = wr_cfg.pre_div;
      sh_d.per_div = per_w;
      sh_d.hi_cnt  = ({1'b0, wr_cfg.hi_cnt} > hi_lim) ? hi_lim[PWM_W-1:0]
                                                     : wr_cfg.hi_cnt;
    end
  end

  // Active next state: copied only on a boundary or while idle
  always_comb begin
    act_d = load ? sh_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      sh_q  <= sh_d;
      act_q <= act_d;
    end
  end

  assert_per_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_q.per_div <= PER_MAX);

  assert_hi_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, act_q.hi_cnt} <= ({1'b0, act_q.per_div} + XW'(1)));

  assert_hold_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q));
endmodule

// File: rtl/pwm_mod_counter.sv
module pwm_mod_counter
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [PWM_W-1:0] limit,
  output logic [PWM_W-1:0] cnt_q,
  output logic [PWM_W-1:0] cnt_d,
  output logic             last
);
  logic at_lim;

  always_comb begin
    at_lim = (cnt_q == limit);
    last   = step && at_lim;
    if (clr)        cnt_d = '0;
    else if (last)  cnt_d = '0;
    else if (step)  cnt_d = cnt_q + PWM_W'(1);
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PWM_W-1:0] pos_d,
  input  logic [PWM_W-1:0] hi_d,
  output logic             pwm_q
);
  logic pwm_d;

  // Compare against the next counter position so the output lines up
  always_comb begin
    pwm_d = en && (pos_d < hi_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assert_off_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_q);
endmodule

// File: rtl/pwm_prescaled_gen.sv
module pwm_prescaled_gen
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_we,
  input  logic [PWM_W-1:0] cfg_prescale,
  input  logic [PWM_W-1:0] cfg_period,
  input  logic [PWM_W-1:0] cfg_high,
  output logic             pwm_out
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_li_n;
  logic                   run_q;
  logic                   run_go;
  logic                   load;
  logic                   tick;
  logic                   wrap;
  pwm_cfg_t               wr_cfg, act_q, act_d;
  logic [PWM_W-1:0]       pre_q, pre_d, per_q, per_d;

  // Reset: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_li_n = rst_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_li_n) begin
    if (!rst_li_n) run_q <= 1'b0;
    else           run_q <= en;
  end

  always_comb begin
    run_go         = en && run_q;
    load           = !run_go || wrap;
    wr_cfg.pre_div = cfg_prescale;
    wr_cfg.per_div = cfg_period;
    wr_cfg.hi_cnt  = cfg_high;
  end

  pwm_cfg_bank u_cfg (
    .clk    (clk),
    .rst_n  (rst_li_n),
    .wr_en  (cfg_we),
    .wr_cfg (wr_cfg),
    .load   (load),
    .act_q  (act_q),
    .act_d  (act_d)
  );

  pwm_mod_counter u_pre (
    .clk   (clk),
    .rst_n (rst_li_n),
    .clr   (!run_go),
    .step  (run_go),
    .limit (act_q.pre_div),
    .cnt_q (pre_q),
    .cnt_d (pre_d),
    .last  (tick)
  );

  pwm_mod_counter u_per (
    .clk   (clk),
    .rst_n (rst_li_n),
    .clr   (!run_go),
    .step  (tick),
    .limit (act_q.per_div),
    .cnt_q (per_q),
    .cnt_d (per_d),
    .last  (wrap)
  );

  pwm_duty_cmp u_cmp (
    .clk   (clk),
    .rst_n (rst_li_n),
    .en    (en),
    .pos_d (per_d),
    .hi_d  (act_d.hi_cnt),
    .pwm_q (pwm_out)
  );

  assert_zero_duty_R4: assert property (@(posedge clk) disable iff (!rst_li_n)
    (run_q && act_q.hi_cnt == '0) |-> !pwm_out);

  assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_li_n)
    (run_q && act_q.hi_cnt == act_q.per_div + PWM_W'(1)) |-> pwm_out);

  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_li_n)
    !en |=> (pre_q == '0 && per_q == '0));
endmodule

// File: tb/pwm_prescaled_gen_tb.sv
module pwm_prescaled_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        cfg_we;
  logic [15:0] cfg_prescale, cfg_period, cfg_high;
  logic        pwm_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwm_prescaled_gen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .cfg_we       (cfg_we),
    .cfg_prescale (cfg_prescale),
    .cfg_period   (cfg_period),
    .cfg_high     (cfg_high),
    .pwm_out      (pwm_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input int p, input int d, input int h);
    @(negedge clk);
    cfg_prescale = 16'(p); cfg_period = 16'(d); cfg_high = 16'(h);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic restart(input int p, input int d, input int h);
    @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);
    write_cfg(p, d, h);
    en = 1'b1;
  endtask

  task automatic wait_rise();
    logic prev;
    prev = pwm_out;
    for (int i = 0; i < 150000; i++) begin
      @(negedge clk);
      if (!prev && pwm_out) return;
      prev = pwm_out;
    end
  endtask

  // Called on the sample where pwm_out has just risen; returns on the next rise
  task automatic measure(input int wr_at, input int p2, input int d2, input int h2,
                         output int hi, output int len);
    bit seen_low = 0;
    hi = 0; len = 0;
    for (int i = 0; i < 150000; i++) begin
      if (pwm_out) begin
        if (seen_low) break;
        hi++;
      end else seen_low = 1;
      if (len == wr_at) begin
        cfg_prescale = 16'(p2); cfg_period = 16'(d2); cfg_high = 16'(h2);
        cfg_we = 1'b1;
      end
      len++;
      @(negedge clk);
      cfg_we = 1'b0;
    end
  endtask

  task automatic count_level(input int cycles, input logic lvl, output int bad);
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_out !== lvl) bad++;
    end
  endtask

  task automatic t_reset();
    int bad;
    rst_n = 1'b0; en = 1'b1; cfg_we = 1'b1;
    cfg_prescale = 16'd0; cfg_period = 16'd3; cfg_high = 16'd4;
    repeat (3) @(negedge clk);
    chk("R1", "out during reset", int'(pwm_out), 0);
    en = 1'b0; cfg_we = 1'b0;
    rst_n = 1'b1;
    count_level(20, 1'b0, bad);
    chk("R1", "low cycles missed while idle", bad, 0);
  endtask

  task automatic t_pattern(input int p, input int d, input int h);
    int hi, len;
    restart(p, d, h);
    wait_rise();
    measure(-1, 0, 0, 0, hi, len);
    chk("R3", $sformatf("high time P%0d D%0d H%0d", p, d, h), hi, h * (p + 1));
    chk("R2", $sformatf("period P%0d D%0d", p, d), len, (p + 1) * (d + 1));
  endtask

  task automatic t_level(input string req, input int p, input int d, input int h,
                         input logic lvl, input int cycles);
    int bad;
    restart(p, d, h);
    @(negedge clk);
    count_level(cycles, lvl, bad);
    chk(req, "cycles at wrong level", bad, 0);
  endtask

  task automatic t_update_R8();
    int hi, len;
    restart(0, 19, 5);
    wait_rise();
    measure(8, 0, 9, 7, hi, len);
    chk("R8", "old high time kept", hi, 5);
    chk("R8", "old period kept", len, 20);
    measure(-1, 0, 0, 0, hi, len);
    chk("R8", "new high time", hi, 7);
    chk("R8", "new period", len, 10);
  endtask

  task automatic t_enable_R9();
    int hi, len, bad;
    restart(0, 19, 10);
    wait_rise();
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R9", "out after disable", int'(pwm_out), 0);
    count_level(20, 1'b0, bad);
    chk("R9", "low while disabled", bad, 0);
    write_cfg(1, 7, 4);
    en = 1'b1;
    @(negedge clk);
    chk("R9", "out on first enabled cycle", int'(pwm_out), 1);
    measure(-1, 0, 0, 0, hi, len);
    chk("R9", "fresh high time", hi, 8);
    chk("R9", "fresh period", len, 16);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_pattern(0, 9, 3);
    t_pattern(2, 4, 2);
    t_pattern(1, 6, 5);
    t_pattern(4, 3, 1);
    t_level("R4", 0, 5, 0, 1'b0, 50);
    t_level("R5", 1, 5, 6, 1'b1, 50);
    t_level("R6", 0, 5, 200, 1'b1, 50);
    t_level("R7", 0, 16'hFFFF, 16'hFFFF, 1'b1, 300);
    t_update_R8();
    t_enable_R9();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule